// File: doc/BRIEF.md
# Watchdog Register Block with Bit-Set and Bit-Clear Aliases

This block is a memory-mapped watchdog timer of the kind found in a real-time-clock register bank. A 32-bit register port reaches six register groups. Each group occupies 16 bytes. Within a group, the word at +0x0 is the register itself, the word at +0x4 ORs the written ones into it, and the word at +0x8 clears the written ones from it. Because of these aliases, software can change a single bit without a read-modify-write sequence.

A countdown holds the timeout in milliseconds and moves on a 1 kHz tick strobe. While the countdown runs, any write to the count group reloads it, and this is how software services the watchdog. When the countdown reaches zero, the block raises a one-clock reset request and latches a cause flag.

Two persistent registers hold reset-cause flags. Only the power-on reset input clears them. The system reset, which the reset request normally drives, leaves them unchanged, so software can still read them after the watchdog has fired.

Top module: `wdog_rtc_regs`

## Requirements
- R1: After the system reset and the power-on reset, the registers read as follows: control at 0x00 is 0, count at 0x50 is 0, debug at 0xC0 is 0, and both persistent registers at 0x60 and 0x70 are 0. Status at 0x10 reads 0x2000_0000, which is bit 29, the presence flag. `reset_req` is low.
- R2: A write to the base word of a group (group offset +0x0) replaces that register. A read of the same word returns the new value.
- R3: A write to +0x4 of a group ORs the data into the register. A write to +0x8 clears the bits that are one in the data. A read from +0x4 or +0x8 returns the value of the register.
- R4: The countdown runs when control bit 4 is 1 and the debug register is 0. While it runs, each cycle with `tick_1k` high lowers a nonzero count by one. Without a tick the count stays unchanged.
- R5: When the debug register is nonzero or control bit 4 is 0, ticks leave the count unchanged.
- R6: When a running countdown steps from 1 to 0, `reset_req` is high for exactly one clock, in the cycle after the tick. In the same cycle, bit 31 of the register at 0x70 is set. A count that is already 0 raises no further request.
- R7: Any write to the count group reloads the count at once. The write takes priority over a tick in the same cycle.
- R8: The registers at 0x60 and 0x70 keep their value through the system reset. Only `por_n` clears them.
- R9: Group offset +0xC and unmapped groups read as 0. Writes to them change no register.
- R10: The status register ignores writes made through any of its three words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the persistent registers, active low |
| tick_1k | input | 1 | One-clock strobe at 1 kHz |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte address of the register word |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from the address |
| reset_req | output | 1 | One-clock reset request on expiry |

## Verification
Random writes through plain, set and clear words go to the four writable registers, each followed by a read through a randomly chosen word. This separates replace, OR and clear-bits behaviour, and it confirms that the aliases read back the register. Random load values and tick counts check the decrement arithmetic.

Directed cases cover four corner conditions:
- a write and a tick landing in the same cycle, which shows the priority of the reload;
- the step from 1 to 0, followed by an extra tick, which shows the single pulse;
- the debug register and the enable bit, each freezing the count on its own;
- a system reset followed by a power-on reset, which shows which registers survive.

// File: rtl/wdog_rtc_regs.sv
module wdog_rtc_regs #(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int EN_BIT      = 4,
  parameter int PRESENT_BIT = 29,
  parameter int CAUSE_BIT   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          tick_1k,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          reset_req
);
  localparam int GW = AW - 4;
  localparam logic [GW-1:0] G_CTRL = GW'(4'h0);
  localparam logic [GW-1:0] G_STAT = GW'(4'h1);
  localparam logic [GW-1:0] G_CNT  = GW'(4'h5);
  localparam logic [GW-1:0] G_P0   = GW'(4'h6);
  localparam logic [GW-1:0] G_P1   = GW'(4'h7);
  localparam logic [GW-1:0] G_DBG  = GW'(4'hC);
  localparam logic [DW-1:0] STATUS = DW'(1) << PRESENT_BIT;

  logic [DW-1:0] ctrl_q, cnt_q, dbg_q, p0_q, p1_q, p1_d;

  wire [GW-1:0] grp   = bus_addr[AW-1:4];
  wire [1:0]    op    = bus_addr[3:2];
  wire          op_ok = (op != 2'd3);
  wire          wr_ok = bus_wr && op_ok;

  wire wr_ctrl = wr_ok && grp == G_CTRL;
  wire wr_cnt  = wr_ok && grp == G_CNT;
  wire wr_dbg  = wr_ok && grp == G_DBG;
  wire wr_p0   = wr_ok && grp == G_P0;
  wire wr_p1   = wr_ok && grp == G_P1;

  wire running = ctrl_q[EN_BIT] && dbg_q == '0;
  wire step    = tick_1k && running && cnt_q != '0 && !wr_cnt;
  wire expire  = step && cnt_q == DW'(1);

  function automatic logic [DW-1:0] upd(input logic [DW-1:0] cur);
    case (op)
      2'd0:    upd = bus_wdata;
      2'd1:    upd = cur | bus_wdata;
      2'd2:    upd = cur & ~bus_wdata;
      default: upd = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dbg_q     <= '0;
      cnt_q     <= '0;
      reset_req <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= upd(ctrl_q);
      if (wr_dbg)  dbg_q  <= upd(dbg_q);
      if (wr_cnt)     cnt_q <= upd(cnt_q);
      else if (step)  cnt_q <= cnt_q - DW'(1);
      reset_req <= expire;
    end
  end

  always_comb begin
    p1_d = wr_p1 ? upd(p1_q) : p1_q;
    if (expire) p1_d[CAUSE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      p0_q <= '0;
      p1_q <= '0;
    end else begin
      if (wr_p0) p0_q <= upd(p0_q);
      p1_q <= p1_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (op_ok) begin
      case (grp)
        G_CTRL:  bus_rdata = ctrl_q;
        G_STAT:  bus_rdata = STATUS;
        G_CNT:   bus_rdata = cnt_q;
        G_P0:    bus_rdata = p0_q;
        G_P1:    bus_rdata = p1_q;
        G_DBG:   bus_rdata = dbg_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_rtc_regs_chk.sv
module wdog_rtc_regs_chk #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int EN_BIT    = 4,
  parameter int CAUSE_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          tick_1k,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          reset_req,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] dbg_q,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] p1_q
);
  wire cnt_wr = bus_wr && bus_addr[AW-1:4] == (AW-4)'(5) && bus_addr[3:2] != 2'd3;
  wire p1_wr  = bus_wr && bus_addr[AW-1:4] == (AW-4)'(7) && bus_addr[3:2] != 2'd3;

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1k && !cnt_wr) |=> $stable(cnt_q));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1k && ctrl_q[EN_BIT] && dbg_q == '0 && cnt_q != '0 && !cnt_wr)
      |=> cnt_q == $past(cnt_q) - DW'(1));

  p_debug_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_q != '0 && !cnt_wr) |=> $stable(cnt_q));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_pulse_sets_cause_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reset_req |-> p1_q[CAUSE_BIT]);

  p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (p1_q[CAUSE_BIT] && !p1_wr) |=> p1_q[CAUSE_BIT]);
endmodule

bind wdog_rtc_regs wdog_rtc_regs_chk #(
  .AW(AW), .DW(DW), .EN_BIT(EN_BIT), .CAUSE_BIT(CAUSE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_1k(tick_1k),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .reset_req(reset_req),
  .ctrl_q(ctrl_q), .dbg_q(dbg_q), .cnt_q(cnt_q), .p1_q(p1_q)
);

// File: tb/tb_wdog_rtc_regs.sv
module tb_wdog_rtc_regs;
  logic clk = 0, rst_n = 0, por_n = 0, tick = 0, bwr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, v;
  logic        rreq;
  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] model [4];

  wdog_rtc_regs dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_1k(tick),
    .bus_wr(bwr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .reset_req(rreq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bwr = 1; addr = a; wdata = d;
    @(negedge clk); bwr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk); addr = a; #1 r = rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [31:0] apply(input logic [31:0] c, input int op, input logic [31:0] d);
    if (op == 0) return d;
    if (op == 1) return c | d;
    return c & ~d;
  endfunction

  function automatic logic [7:0] base_of(input int i);
    case (i)
      0: return 8'h00;
      1: return 8'h60;
      2: return 8'h70;
      default: return 8'hC0;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int load, k;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1; por_n = 1;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h50, v); chk("R1 count", v, 0);
    rd(8'hC0, v); chk("R1 debug", v, 0);
    rd(8'h60, v); chk("R1 pers0", v, 0);
    rd(8'h70, v); chk("R1 pers1", v, 0);
    rd(8'h10, v); chk("R1 status", v, 32'h2000_0000);
    chk("R1 reset_req", {31'd0, rreq}, 0);

    // R2 direct write
    wr(8'hC0, 32'hA5A5_0000); rd(8'hC0, v); chk("R2 debug", v, 32'hA5A5_0000);
    wr(8'hC0, 0);
    wr(8'h60, 32'h1234_5678); rd(8'h60, v); chk("R2 pers0", v, 32'h1234_5678);

    // R3 directed set / clear
    wr(8'h04, 32'h10);
    rd(8'h04, v); chk("R3 set alias read", v, 32'h10);
    rd(8'h08, v); chk("R3 clear alias read", v, 32'h10);
    wr(8'h08, 32'h10); rd(8'h00, v); chk("R3 clear", v, 0);
    wr(8'h60, 32'h0030_0080); wr(8'h68, 32'h0020_0000);
    rd(8'h60, v); chk("R3 pers0 clear bit", v, 32'h0010_0080);

    // R3 random set/clear/write
    for (int i = 0; i < 4; i++) begin wr(base_of(i), 0); model[i] = 0; end
    for (int n = 0; n < 60; n++) begin
      int r, op, ro;
      logic [31:0] d;
      r = $urandom_range(3); op = $urandom_range(2); ro = $urandom_range(2);
      d = $urandom;
      wr(base_of(r) + 8'(op * 4), d);
      model[r] = apply(model[r], op, d);
      rd(base_of(r) + 8'(ro * 4), v);
      chk("R3 random alias", v, model[r]);
    end
    wr(8'h00, 0); wr(8'hC0, 0); wr(8'h70, 0);
    model[0] = 0; model[2] = 0; model[3] = 0;

    // R4 random countdown
    load = 5 + $urandom_range(25);
    k = 1 + $urandom_range(load - 3);
    wr(8'h50, 32'(load)); wr(8'h04, 32'h10);
    repeat (3) @(negedge clk);
    rd(8'h50, v); chk("R4 hold without tick", v, 32'(load));
    for (int t = 0; t < k; t++) begin
      tk();
      repeat ($urandom_range(2)) @(negedge clk);
    end
    rd(8'h50, v); chk("R4 decrement", v, 32'(load - k));

    // R5 freeze by debug, then by enable
    wr(8'hC4, 32'h1);
    repeat (3) tk();
    rd(8'h50, v); chk("R5 debug freeze", v, 32'(load - k));
    wr(8'hC0, 0); wr(8'h08, 32'h10);
    repeat (2) tk();
    rd(8'h50, v); chk("R5 enable freeze", v, 32'(load - k));
    wr(8'h04, 32'h10);

    // R7 kick wins over simultaneous tick
    @(negedge clk); tick = 1; bwr = 1; addr = 8'h50; wdata = 2;
    @(negedge clk); tick = 0; bwr = 0;
    rd(8'h50, v); chk("R7 reload priority", v, 2);

    // R6 expiry
    tk();
    chk("R6 no early request", {31'd0, rreq}, 0);
    rd(8'h50, v); chk("R6 count one", v, 1);
    tk();
    chk("R6 request high", {31'd0, rreq}, 1);
    @(negedge clk);
    chk("R6 request one clock", {31'd0, rreq}, 0);
    rd(8'h50, v); chk("R6 count zero", v, 0);
    rd(8'h70, v); chk("R6 cause set", v, 32'h8000_0000);
    tk(); @(negedge clk);
    chk("R6 no repeat at zero", {31'd0, rreq}, 0);

    // R8 persistence over system reset
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(8'h70, v); chk("R8 cause survives", v, 32'h8000_0000);
    rd(8'h60, v); chk("R8 pers0 survives", v, model[1]);
    rd(8'h00, v); chk("R8 ctrl reset", v, 0);
    wr(8'h78, 32'h8000_0000); rd(8'h70, v); chk("R3 clear cause", v, 0);
    wr(8'h74, 32'h8000_0000);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    rd(8'h70, v); chk("R8 por clears pers1", v, 0);
    rd(8'h60, v); chk("R8 por clears pers0", v, 0);

    // R9 unmapped
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R9 offset C", v, 0);
    rd(8'h00, v); chk("R9 ctrl untouched", v, 0);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v); chk("R9 unmapped group", v, 0);
    rd(8'h5C, v); chk("R9 count offset C", v, 0);

    // R10 status read-only
    wr(8'h10, 0); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 status", v, 32'h2000_0000);
    rd(8'h14, v); chk("R10 status alias", v, 32'h2000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule